// File: doc/BRIEF.md
# Ramp-Compare PWM Modulator

This block turns a digitized error code into one fixed-frequency drive pulse per switching period. A free-running ramp counter advances by one step on every period tick. At the first step of each period the error code and the programmed duty limit are sampled and converted into a duty count. The active drive line is then held high while the ramp is below that count.

The error code uses a 0..5 scale at 64 codes per unit. The ramp window runs from 0.5 (code 32) to 4.5 (code 288) and maps onto the ramp's 256 counts. Below the window both lines stay low. Above it the block applies the largest duty allowed, which is the programmed limit or a fixed 98% ceiling (250 of 256 counts), whichever is smaller.

A conversion-mode bit is captured while the block is disabled. It selects which one of the two drive lines switches; the other line is held low for the whole enabled interval. Dropping the enable qualifier silences both lines and returns the ramp to the start of a period.

Top module: `pwm_modulator`

## Requirements
- R1: After reset both drive lines and the period-start strobe are low, and the ramp stands at count 0, so the first enabled tick opens a period.
- R2: The ramp is an 8-bit counter that advances by one on each enabled tick and wraps from 255 to 0, giving 256 ticks per period. On the tick taken at count 0, the period-start strobe goes high for exactly one clock.
- R3: An error code below 32 gives a duty of zero, so both drive lines stay low for the whole period. Code 32 itself also gives zero duty.
- R4: An error code e with 32 <= e < 288 gives a raw duty of e-32 ticks. The active line is high for ramp counts 0 up to duty-1.
- R5: An error code of 288 or more gives the maximum allowed duty.
- R6: The maximum allowed duty is the 8-bit limit code when that code is 250 or less, and 250 otherwise. The value 255 means no limit is programmed. The applied duty is the smaller of the raw duty and the maximum allowed duty.
- R7: The error and limit codes are sampled only on the tick at count 0. Any change during a period takes effect in the next period.
- R8: Mode 1 (buck) switches only the high-side line and mode 0 (boost) switches only the low-side line. The other line stays low, and the two lines are never high together.
- R9: The mode bit is captured on every clock while enable is low. Changes made while enable is high have no effect until the next disabled interval.
- R10: One clock after enable is seen low, both lines and the strobe are low and the ramp is back at 0.
- R11: Drive lines change only on clocks where an enabled tick was present. Between ticks they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run qualifier; low disables and rewinds the ramp |
| tick_i | input | 1 | Ramp step request, one clock wide |
| mode_i | input | 1 | Conversion mode: 1 buck, 0 boost |
| err_i | input | 9 | Error code, 64 codes per unit on a 0..5 scale |
| dmax_i | input | 8 | Programmed duty limit in ramp counts |
| hs_o | output | 1 | High-side drive line |
| ls_o | output | 1 | Low-side drive line |
| start_o | output | 1 | Period-start strobe |

## Verification
Two functions can fall on the same clock. The first is the sampling of new error and limit codes: that tick both opens a period and drives the first pulse step. The second is disable, which may land mid-period while a pulse is high, and must override the step and rewind the ramp at once. The bench changes codes on the last step of a period, and again deep inside a period. It also drops enable while the high-side line is active. Each case is judged against a behavioural per-clock model and by measuring pulse widths against values worked out from the requirements.

// File: rtl/pwm_mod_pkg.sv
package pwm_mod_pkg;

    typedef enum logic {
        MODE_BOOST = 1'b0,
        MODE_BUCK  = 1'b1
    } conv_mode_e;

    // Default geometry shared by the modulator pieces.
    localparam int unsigned DEF_CNT_W     = 8;
    localparam int unsigned DEF_ERR_FLOOR = 32;
    localparam int unsigned DEF_CEIL_PCT  = 98;

    function automatic int unsigned ceil_counts(input int unsigned cnt_w,
                                                input int unsigned pct);
        return ((2 ** cnt_w) * pct) / 100;
    endfunction

endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_start_o,
    output logic             step_o
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ramp_s;

    ramp_s ramp_d, ramp_q;

    always_comb begin
        ramp_d = ramp_q;
        if (!en_i) begin
            ramp_d.cnt = '0;
        end else if (tick_i) begin
            ramp_d.cnt = ramp_q.cnt + ONE;
        end
        cnt_o      = ramp_q.cnt;
        at_start_o = (ramp_q.cnt == '0);
        step_o     = en_i & tick_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_q <= '0;
        end else begin
            ramp_q <= ramp_d;
        end
    end

    // R2: terminal count wraps to the period start
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && cnt_o == LAST) |=> (cnt_o == '0));

    // R2: each enabled tick advances the ramp by exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i) |=> (cnt_o == $past(cnt_o) + ONE));

    // R10: a disabled clock rewinds the ramp
    p_rewind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_o == '0));

endmodule

// File: rtl/pwm_duty_calc.sv
module pwm_duty_calc #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned ERR_W     = CNT_W + 1,
    parameter int unsigned ERR_FLOOR = 32,
    parameter int unsigned CEIL_CNT  = 250
) (
    input  logic [ERR_W-1:0] err_i,
    input  logic [CNT_W-1:0] dmax_i,
    output logic [CNT_W-1:0] duty_o,
    output logic             dead_o
);
    localparam int unsigned RANGE = 2 ** CNT_W;
    localparam int unsigned SAT   = ERR_FLOOR + RANGE;

    localparam logic [ERR_W-1:0] FLOOR_C = ERR_W'(ERR_FLOOR);
    localparam logic [ERR_W:0]   SAT_C   = (ERR_W+1)'(SAT);
    localparam logic [CNT_W:0]   RANGE_C = (CNT_W+1)'(RANGE);
    localparam logic [CNT_W:0]   CEIL_C  = (CNT_W+1)'(CEIL_CNT);

    logic             sat;
    logic [ERR_W-1:0] offset;
    logic [CNT_W:0]   raw;
    logic [CNT_W:0]   lim;
    logic             raw_wins;

    always_comb begin
        dead_o = (err_i < FLOOR_C);
        sat    = ({1'b0, err_i} >= SAT_C);
        offset = err_i - FLOOR_C;
        if (dead_o) begin
            raw = '0;
        end else if (sat) begin
            raw = RANGE_C;
        end else begin
            raw = (CNT_W+1)'(offset);
        end
        if ({1'b0, dmax_i} > CEIL_C) begin
            lim = CEIL_C;
        end else begin
            lim = {1'b0, dmax_i};
        end
        raw_wins = (raw < lim);
        duty_o   = raw_wins ? raw[CNT_W-1:0] : lim[CNT_W-1:0];
    end

endmodule

// File: rtl/pwm_drive.sv
module pwm_drive
    import pwm_mod_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned CEIL_CNT = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             step_i,
    input  logic             at_start_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             mode_i,
    output logic             hs_o,
    output logic             ls_o,
    output logic             start_o
);
    typedef struct packed {
        logic [CNT_W-1:0] duty;
        conv_mode_e       mode;
        logic             hs;
        logic             ls;
        logic             start;
    } drive_s;

    drive_s drv_d, drv_q;
    logic [CNT_W-1:0] duty_eff;
    logic             pulse;

    always_comb begin
        drv_d       = drv_q;
        drv_d.start = 1'b0;
        duty_eff    = at_start_i ? duty_i : drv_q.duty;
        pulse       = (cnt_i < duty_eff);
        if (!en_i) begin
            drv_d.duty = '0;
            drv_d.mode = conv_mode_e'(mode_i);
            drv_d.hs   = 1'b0;
            drv_d.ls   = 1'b0;
        end else if (step_i) begin
            drv_d.duty  = duty_eff;
            drv_d.start = at_start_i;
            drv_d.hs    = pulse && (drv_q.mode == MODE_BUCK);
            drv_d.ls    = pulse && (drv_q.mode == MODE_BOOST);
        end
        hs_o    = drv_q.hs;
        ls_o    = drv_q.ls;
        start_o = drv_q.start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '{duty: '0, mode: MODE_BOOST, hs: 1'b0, ls: 1'b0, start: 1'b0};
        end else begin
            drv_q <= drv_d;
        end
    end

    // R8: the two drive lines are mutually exclusive
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && ls_o));

    // R8: buck mode never raises the low-side line
    p_buck_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_q.mode == MODE_BUCK) |-> !ls_o);

    // R9: captured mode holds while enabled
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> $stable(drv_q.mode));

    // R10: disable silences every output on the next clock
    p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!hs_o && !ls_o && !start_o));

    // R11: no tick, no change on the drive lines
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !step_i) |=> ($stable(hs_o) && $stable(ls_o) && !start_o));

    // R6: the held duty never passes the fixed ceiling
    p_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q.duty <= CNT_W'(CEIL_CNT));

endmodule

// File: rtl/pwm_modulator.sv
module pwm_modulator
    import pwm_mod_pkg::*;
#(
    parameter int unsigned CNT_W     = DEF_CNT_W,
    parameter int unsigned ERR_FLOOR = DEF_ERR_FLOOR,
    parameter int unsigned CEIL_PCT  = DEF_CEIL_PCT,
    localparam int unsigned ERR_W    = CNT_W + 1,
    localparam int unsigned CEIL_CNT = ceil_counts(CNT_W, CEIL_PCT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             mode_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic [CNT_W-1:0] dmax_i,
    output logic             hs_o,
    output logic             ls_o,
    output logic             start_o
);
    logic [CNT_W-1:0] ramp_cnt;
    logic             ramp_start;
    logic             ramp_step;
    logic [CNT_W-1:0] duty_new;
    logic             err_dead;

    pwm_ramp #(
        .CNT_W (CNT_W)
    ) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .tick_i     (tick_i),
        .cnt_o      (ramp_cnt),
        .at_start_o (ramp_start),
        .step_o     (ramp_step)
    );

    pwm_duty_calc #(
        .CNT_W     (CNT_W),
        .ERR_W     (ERR_W),
        .ERR_FLOOR (ERR_FLOOR),
        .CEIL_CNT  (CEIL_CNT)
    ) u_duty (
        .err_i  (err_i),
        .dmax_i (dmax_i),
        .duty_o (duty_new),
        .dead_o (err_dead)
    );

    pwm_drive #(
        .CNT_W    (CNT_W),
        .CEIL_CNT (CEIL_CNT)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .step_i     (ramp_step),
        .at_start_i (ramp_start),
        .cnt_i      (ramp_cnt),
        .duty_i     (duty_new),
        .mode_i     (mode_i),
        .hs_o       (hs_o),
        .ls_o       (ls_o),
        .start_o    (start_o)
    );

    // R3: a dead-zone code sampled at period start keeps both lines low
    p_dead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && ramp_start && err_dead) |=> (!hs_o && !ls_o));

    // R2: the strobe follows the enabled tick taken at count 0
    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && ramp_start) |=> start_o);

endmodule

// File: tb/sim_pwm_modulator.sv
module sim_pwm_modulator;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic       mode = 1'b1;
    logic [8:0] err = '0;
    logic [7:0] dmax = 8'hFF;
    logic       hs, ls, st;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    model_on = 1'b0;

    int m_cnt = 0;
    int m_duty = 0;
    bit m_mode = 1'b0;
    bit m_hs = 1'b0, m_ls = 1'b0, m_st = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    pwm_modulator u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .tick_i  (tick),
        .mode_i  (mode),
        .err_i   (err),
        .dmax_i  (dmax),
        .hs_o    (hs),
        .ls_o    (ls),
        .start_o (st)
    );

    function automatic int want_duty(input int e, input int d);
        int raw, lim;
        if (e < 32)        raw = 0;
        else if (e >= 288) raw = 256;
        else               raw = e - 32;
        lim = (d > 250) ? 250 : d;
        return (raw < lim) ? raw : lim;
    endfunction

    // Behavioural reference, advanced on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_duty = 0; m_mode = 1'b0;
            m_hs = 1'b0; m_ls = 1'b0; m_st = 1'b0;
        end else if (!en) begin
            m_cnt = 0; m_duty = 0; m_mode = mode;
            m_hs = 1'b0; m_ls = 1'b0; m_st = 1'b0;
        end else if (tick) begin
            m_st = (m_cnt == 0);
            if (m_cnt == 0) m_duty = want_duty(int'(err), int'(dmax));
            m_hs = (m_cnt < m_duty) && m_mode;
            m_ls = (m_cnt < m_duty) && !m_mode;
            m_cnt = (m_cnt + 1) % 256;
        end else begin
            m_st = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if (hs !== m_hs || ls !== m_ls || st !== m_st) begin
                fails++;
                $display("FAIL %s per-clock: actual hs/ls/st=%b%b%b expected %b%b%b at %0t",
                         cur_req, hs, ls, st, m_hs, m_ls, m_st, $time);
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One aligned period; tick every g clocks; optional code change after step chg_at
    task automatic run_period(input int e, input int d, input int g, input bit buck,
                              input int exp_w, input string req,
                              input int chg_at, input int chg_e, input int chg_d);
        int n_hs = 0, n_ls = 0, n_st = 0, first_st = 0;
        cur_req = req;
        err = 9'(e);
        dmax = 8'(d);
        for (int s = 0; s < 256; s++) begin
            tick = 1'b1;
            @(negedge clk);
            if (s == 0) first_st = int'(st);
            n_hs += int'(hs); n_ls += int'(ls); n_st += int'(st);
            tick = 1'b0;
            for (int k = 1; k < g; k++) begin
                @(negedge clk);
                n_hs += int'(hs); n_ls += int'(ls); n_st += int'(st);
            end
            if (s == chg_at) begin
                err = 9'(chg_e);
                dmax = 8'(chg_d);
            end
        end
        chk(req, "active-line width", buck ? n_hs : n_ls, exp_w * g);
        chk(req, "idle-line width", buck ? n_ls : n_hs, 0);
        chk("R2", "strobe count", n_st, 1);
        chk("R2", "strobe on first step", first_st, 1);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000);
        fails++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        model_on = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "hs after reset", int'(hs), 0);
        chk("R1", "ls after reset", int'(ls), 0);
        chk("R1", "strobe after reset", int'(st), 0);
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);

        run_period(132, 255, 1, 1'b1, 100, "R4", -1, 0, 0);
        run_period(33,  255, 1, 1'b1, 1,   "R4", -1, 0, 0);
        run_period(20,  255, 1, 1'b1, 0,   "R3", -1, 0, 0);
        run_period(32,  255, 1, 1'b1, 0,   "R3", -1, 0, 0);
        run_period(400, 255, 1, 1'b1, 250, "R5", -1, 0, 0);
        run_period(288, 200, 1, 1'b1, 200, "R5", -1, 0, 0);
        run_period(400, 80,  1, 1'b1, 80,  "R6", -1, 0, 0);
        run_period(200, 120, 1, 1'b1, 120, "R6", -1, 0, 0);
        run_period(287, 251, 1, 1'b1, 250, "R6", -1, 0, 0);
        // R7: change codes mid-period, then on the final step before the wrap
        run_period(132, 255, 1, 1'b1, 100, "R7", 40, 300, 10);
        run_period(300, 10,  1, 1'b1, 10,  "R7", 255, 100, 255);
        run_period(100, 255, 1, 1'b1, 68,  "R7", -1, 0, 0);
        // R11: slow ticks stretch each step
        run_period(132, 255, 3, 1'b1, 100, "R11", -1, 0, 0);
        // R9: mode change while enabled is ignored
        mode = 1'b0;
        run_period(140, 255, 1, 1'b1, 108, "R9", -1, 0, 0);

        // R10: disable while the high-side line is active
        cur_req = "R10";
        err = 9'd200;
        for (int i = 0; i < 50; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        chk("R10", "hs mid-pulse before disable", int'(hs), 1);
        en = 1'b0;
        @(negedge clk);
        chk("R10", "hs one clock after disable", int'(hs), 0);
        chk("R10", "ls one clock after disable", int'(ls), 0);
        tick = 1'b0;
        en = 1'b1;
        @(negedge clk);
        // R8: boost now captured, low side switches from a fresh period
        run_period(140, 255, 1, 1'b0, 108, "R8", -1, 0, 0);
        run_period(400, 255, 1, 1'b0, 250, "R8", -1, 0, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule